// File: doc/BRIEF.md
# Queued Word DMA Engine with Loopback

This block is a small DMA engine fed by a command queue. Software writes a source address, a destination address, a source word count and a destination word count into four registers. The write to the destination count is the one that commits the command: at that moment a command is built from all four values and pushed into a four-entry queue. The engine takes the command at the head of the queue and moves its data one 32-bit word at a time over a request/acknowledge memory port.

The data can go to one of two places. In stream mode each word read from memory is sent out on a one-cycle stream strobe, and the destination fields are ignored. In loopback mode each word read is written straight back to memory at the destination address. The transfer runs in chunks of at most 1 KB. A partial-done flag is raised at the end of each chunk. When the whole command has finished, it is popped from the queue and both the done and partial-done flags are raised.

The flags sit in a write-one-to-clear interrupt status register. A mask register gates them into a single registered interrupt line. A status register reports whether the queue is full or empty.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset:
  - interrupt status (offset 0x0C) reads 0x88020000, which is bits 31, 27 and 17 set;
  - the mask (0x10) reads 0xFFFFFFFF;
  - the queue status (0x14) reads 0x40000000, with bit 30 (queue empty) set and bit 31 (queue full) clear;
  - irq is 0.
- R2: The address registers (0x18 source, 0x1C destination) read back exactly as written. The length registers (0x20 source, 0x24 destination) keep only their low 27 bits.
- R3: A write to 0x24 enqueues a command with both addresses rounded down to a word boundary. Both lengths count 4-byte words. Every memory request carries a word-aligned address.
- R4: Stream mode applies when bit 4 of the mode register (0x80) is 0 at the start of a command. The engine then reads the source-length count of words from ascending addresses and presents each one on strm_data with strm_valid high for one cycle, in order. The destination length has no effect in this mode.
- R5: Loopback mode applies when bit 4 of 0x80 is 1 at the start of a command. Each word read is written to the destination at ascending addresses. The command moves the smaller of the two lengths in words, memory beyond that point is untouched, and nothing appears on the stream.
- R6: Data moves in chunks of at most CHUNK_WORDS words (256, i.e. 1 KB). Interrupt status bit 12 (partial done) is set at the end of every chunk, including chunks that end before the command does.
- R7: When a command completes, bits 13 (done) and 12 are set and the command leaves the queue. A command with zero length completes without any memory traffic.
- R8: The queue holds QUEUE_DEPTH (4) commands, counting the one in progress. Commands run in the order they were pushed. Bit 31 of 0x14 is set while the queue is full, and bit 30 while it is empty.
- R9: A push into a full queue is dropped and sets interrupt status bit 14 (overflow).
- R10: Writing 1 to a bit of 0x0C clears it. Writing 0 leaves it unchanged.
- R11: irq is high exactly one cycle after any bit is set in (interrupt status AND NOT mask).
- R12: A memory request holds its address and its write enable stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read offset |
| reg_rdata | output | 32 | Read data, one cycle after reg_raddr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Acknowledge of the current request |
| strm_valid | output | 1 | Stream word strobe |
| strm_data | output | 32 | Stream word |
| irq | output | 1 | Registered interrupt line |

## Verification
Four kinds of property are checked on every cycle:
- the memory handshake stays stable and word-aligned while a request waits for its acknowledge;
- the full and empty queue flags are never set together;
- a push into a full queue raises the overflow flag on the next cycle;
- irq rises only when the previous cycle held an unmasked status bit, and never while the mask is all ones.

The data itself can only be shown by the bench's scenarios, which check the stream contents against computed patterns. The same holds for the following:
- what loopback copies, and where it stops;
- the number of words that have passed when the first chunk's partial-done flag appears;
- queue ordering and the dropping of a fifth push.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 27;
  localparam int REG_AW = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [LEN_W-1:0]  src_words;
    logic [LEN_W-1:0]  dst_words;
  } dma_cmd_t;

  localparam logic [REG_AW-1:0] OFS_ISTS  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_IMASK = 8'h10;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SADDR = 8'h18;
  localparam logic [REG_AW-1:0] OFS_DADDR = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_SLEN  = 8'h20;
  localparam logic [REG_AW-1:0] OFS_DLEN  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_MODE  = 8'h80;

  localparam int BIT_FULL  = 31;
  localparam int BIT_EMPTY = 30;
  localparam int BIT_OVF   = 14;
  localparam int BIT_DONE  = 13;
  localparam int BIT_PART  = 12;
  localparam int BIT_LOOP  = 4;

  localparam logic [DATA_W-1:0] ISTS_RESET  = 32'h8802_0000;
  localparam logic [DATA_W-1:0] IMASK_RESET = 32'hFFFF_FFFF;
endpackage

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue
  import cfg_dma_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  dma_cmd_t wr_cmd,
  input  logic     pop,
  output dma_cmd_t head,
  output logic     full,
  output logic     empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dma_cmd_t      store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= wr_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = store[rp];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import cfg_dma_pkg::*;
#(
  parameter int CHUNK_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  dma_cmd_t          head,
  input  logic              loop_mode,
  output logic              pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              strm_valid,
  output logic [DATA_W-1:0] strm_data,
  output logic              chunk_done,
  output logic              cmd_done
);
  localparam int CW = $clog2(CHUNK_WORDS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PLAN, S_READ, S_WRITE, S_STEP, S_FIN} seq_state_e;

  seq_state_e        st;
  logic [ADDR_W-1:0] sa, da;
  logic [LEN_W-1:0]  sl, dl;
  logic              lb;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] dbuf;

  logic [LEN_W-1:0] rem;
  logic [CW-1:0]    take;

  always_comb begin
    rem  = lb ? ((sl < dl) ? sl : dl) : sl;
    take = (rem > LEN_W'(CHUNK_WORDS)) ? CW'(CHUNK_WORDS) : rem[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      sa         <= '0;
      da         <= '0;
      sl         <= '0;
      dl         <= '0;
      lb         <= 1'b0;
      cnt        <= '0;
      dbuf       <= '0;
      strm_valid <= 1'b0;
      strm_data  <= '0;
    end else begin
      strm_valid <= 1'b0;
      case (st)
        S_IDLE: if (!q_empty) begin
          sa <= head.src_addr;
          da <= head.dst_addr;
          sl <= head.src_words;
          dl <= head.dst_words;
          lb <= loop_mode;
          st <= S_PLAN;
        end
        S_PLAN: begin
          if (rem == '0) st <= S_FIN;
          else begin
            cnt <= take;
            st  <= S_READ;
          end
        end
        S_READ: if (mem_ack) begin
          dbuf <= mem_rdata;
          sa   <= sa + ADDR_W'(4);
          sl   <= sl - 1'b1;
          cnt  <= cnt - 1'b1;
          if (lb) st <= S_WRITE;
          else begin
            strm_valid <= 1'b1;
            strm_data  <= mem_rdata;
            st         <= S_STEP;
          end
        end
        S_WRITE: if (mem_ack) begin
          da <= da + ADDR_W'(4);
          dl <= dl - 1'b1;
          st <= S_STEP;
        end
        S_STEP:  st <= (cnt == '0) ? S_PLAN : S_READ;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (st == S_READ) || (st == S_WRITE);
  assign mem_we     = (st == S_WRITE);
  assign mem_addr   = (st == S_WRITE) ? da : sa;
  assign mem_wdata  = dbuf;
  assign chunk_done = (st == S_STEP) && (cnt == '0);
  assign cmd_done   = (st == S_FIN);
  assign pop        = (st == S_FIN);
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import cfg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  input  logic [DATA_W-1:0] set_bits,
  output logic [DATA_W-1:0] sts,
  output logic [DATA_W-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts  <= ISTS_RESET;
      mask <= IMASK_RESET;
      irq  <= 1'b0;
    end else begin
      sts <= (sts & ~clr_bits) | set_bits;
      if (mask_we) mask <= mask_wdata;
      irq <= |(sts & ~mask);
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int CHUNK_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              strm_valid,
  output logic [DATA_W-1:0] strm_data,
  output logic              irq
);
  logic [ADDR_W-1:0] r_saddr, r_daddr;
  logic [LEN_W-1:0]  r_slen, r_dlen;
  logic              r_loop;

  logic              push_cmd, q_full, q_empty, q_pop;
  logic              chunk_done, cmd_done;
  dma_cmd_t          new_cmd, head_cmd;
  logic [DATA_W-1:0] int_sts, int_mask, set_bits, clr_bits;

  assign push_cmd = reg_we && (reg_addr == OFS_DLEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_saddr <= '0;
      r_daddr <= '0;
      r_slen  <= '0;
      r_dlen  <= '0;
      r_loop  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_SADDR: r_saddr <= reg_wdata;
        OFS_DADDR: r_daddr <= reg_wdata;
        OFS_SLEN:  r_slen  <= reg_wdata[LEN_W-1:0];
        OFS_DLEN:  r_dlen  <= reg_wdata[LEN_W-1:0];
        OFS_MODE:  r_loop  <= reg_wdata[BIT_LOOP];
        default:   ;
      endcase
    end
  end

  always_comb begin
    new_cmd.src_addr  = {r_saddr[ADDR_W-1:2], 2'b00};
    new_cmd.dst_addr  = {r_daddr[ADDR_W-1:2], 2'b00};
    new_cmd.src_words = r_slen;
    new_cmd.dst_words = reg_wdata[LEN_W-1:0];
  end

  dma_cmd_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push_cmd), .wr_cmd(new_cmd), .pop(q_pop),
    .head(head_cmd), .full(q_full), .empty(q_empty)
  );

  dma_sequencer #(.CHUNK_WORDS(CHUNK_WORDS)) u_seq (
    .clk(clk), .rst(rst), .q_empty(q_empty), .head(head_cmd), .loop_mode(r_loop),
    .pop(q_pop), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .strm_valid(strm_valid), .strm_data(strm_data),
    .chunk_done(chunk_done), .cmd_done(cmd_done)
  );

  always_comb begin
    set_bits           = '0;
    set_bits[BIT_OVF]  = push_cmd && q_full;
    set_bits[BIT_DONE] = cmd_done;
    set_bits[BIT_PART] = cmd_done || chunk_done;
    clr_bits           = (reg_we && reg_addr == OFS_ISTS) ? reg_wdata : '0;
  end

  dma_irq_regs u_irq (
    .clk(clk), .rst(rst), .clr_bits(clr_bits),
    .mask_we(reg_we && reg_addr == OFS_IMASK), .mask_wdata(reg_wdata),
    .set_bits(set_bits), .sts(int_sts), .mask(int_mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_raddr)
        OFS_ISTS:  reg_rdata <= int_sts;
        OFS_IMASK: reg_rdata <= int_mask;
        OFS_STAT:  reg_rdata <= {q_full, q_empty, 30'd0};
        OFS_SADDR: reg_rdata <= r_saddr;
        OFS_DADDR: reg_rdata <= r_daddr;
        OFS_SLEN:  reg_rdata <= DATA_W'(r_slen);
        OFS_DLEN:  reg_rdata <= DATA_W'(r_dlen);
        OFS_MODE:  reg_rdata <= DATA_W'({r_loop, 4'b0000});
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        irq,
  input logic [31:0] int_sts,
  input logic [31:0] int_mask,
  input logic        q_full,
  input logic        q_empty,
  input logic        push_cmd
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_addr_align_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));

  p_ovf_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (push_cmd && q_full) |=> int_sts[14]);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(int_sts & ~int_mask)));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    $past(&int_mask) |-> !irq);
endmodule

bind cfg_dma_engine cfg_dma_engine_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .irq(irq), .int_sts(int_sts), .int_mask(int_mask),
  .q_full(q_full), .q_empty(q_empty), .push_cmd(push_cmd)
);

// File: tb/sim_cfg_dma_engine.sv
module sim_cfg_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        strm_valid, irq;
  logic [31:0] strm_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dma_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .strm_valid(strm_valid), .strm_data(strm_data), .irq(irq)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0000_9E37);
  endfunction

  // memory model: acknowledge one cycle after a request
  logic [31:0] mem [MEM_WORDS];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= pat(i);
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_req && mem_we && !mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  // stream log and irq rise monitor
  logic [31:0] slog [2048];
  int scount = 0;
  int irq_at;
  logic irq_d = 1'b0;
  always @(posedge clk) begin
    irq_d <= irq;
    if (!rst && irq && !irq_d) irq_at <= scount;
    if (!rst && strm_valid) begin
      slog[scount] <= strm_data;
      scount <= scount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] sa, input logic [31:0] da,
                      input logic [31:0] sl, input logic [31:0] dl);
    wr(8'h18, sa); wr(8'h1C, da); wr(8'h20, sl); wr(8'h24, dl);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n;
    n = 0;
    rd(8'h14, s);
    while (s[30] !== 1'b1 && n < 5000) begin
      rd(8'h14, s);
      n++;
    end
    chk(req, {31'd0, s[30]}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(8'h0C, v); chk("R1 int status", v, 32'h8802_0000);
    rd(8'h10, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R1 queue status", v, 32'h4000_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R10 write-one-to-clear
    wr(8'h0C, 32'h8000_0000); rd(8'h0C, v); chk("R10 clear bit31", v, 32'h0802_0000);
    wr(8'h0C, 32'h0); rd(8'h0C, v); chk("R10 zero write", v, 32'h0802_0000);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R10 clear all", v, 32'h0);

    // R2 register widths
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 length 27 bits", v, 32'h07FF_FFFF);
    wr(8'h18, 32'h0000_0103); rd(8'h18, v); chk("R2 address raw", v, 32'h0000_0103);

    // R3/R4 stream mode, unaligned source, dst length ignored
    base = scount;
    push(32'h0000_0103, 32'h0000_0800, 32'd5, 32'd3);
    wait_idle("R4 stream idle");
    chk("R4 stream count", 32'(scount - base), 32'd5);
    for (int k = 0; k < 5; k++) chk("R3 aligned stream data", slog[base+k], pat(64 + k));
    rd(8'h0C, v); chk("R7 done bits", v & 32'h0000_3000, 32'h0000_3000);

    // R11 interrupt masking
    chk("R11 masked irq", {31'd0, irq}, 32'd0);
    wr(8'h10, ~32'h0000_2000); repeat (2) @(negedge clk);
    chk("R11 irq unmasked", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h0000_2000); repeat (2) @(negedge clk);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);

    // R5 loopback, dst shorter than src
    wr(8'h80, 32'h10);
    base = scount;
    push(32'h0000_0000, 32'h0000_0800, 32'd6, 32'd4);
    wait_idle("R5 loopback idle");
    for (int k = 0; k < 4; k++) chk("R5 copied word", mem[512+k], pat(k));
    chk("R5 beyond dst untouched", mem[516], pat(516));
    // R5 loopback, src shorter than dst
    push(32'h0000_0040, 32'h0000_0A02, 32'd2, 32'd5);
    wait_idle("R5 loopback idle 2");
    chk("R5 short src word0", mem[640], pat(16));
    chk("R5 short src word1", mem[641], pat(17));
    chk("R5 short src stop", mem[642], pat(642));
    chk("R5 no stream", 32'(scount - base), 32'd0);
    wr(8'h80, 32'h0);

    // R7 zero length
    wr(8'h0C, 32'hFFFF_FFFF);
    base = scount;
    push(32'h0, 32'h0, 32'd0, 32'd0);
    wait_idle("R7 zero idle");
    rd(8'h0C, v); chk("R7 zero-length done", v & 32'h0000_3000, 32'h0000_3000);
    chk("R7 zero-length no data", 32'(scount - base), 32'd0);

    // R6 chunking: partial done after 256 words of a 300-word command
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, ~32'h0000_1000);
    base = scount;
    push(32'h0, 32'h0, 32'd300, 32'd0);
    wait_idle("R6 chunk idle");
    chk("R6 words at first partial", 32'(irq_at - base), 32'd256);
    chk("R6 total words", 32'(scount - base), 32'd300);
    for (int k = 0; k < 300; k += 37) chk("R6 chunk data", slog[base+k], pat(k));
    chk("R6 last word", slog[base+299], pat(299));
    wr(8'h10, 32'hFFFF_FFFF);

    // R8/R9 queue full, overflow, ordering
    wr(8'h0C, 32'hFFFF_FFFF);
    base = scount;
    push(32'h0, 32'h0, 32'd300, 32'd0);
    push(32'h400, 32'h0, 32'd1, 32'd0);
    push(32'h404, 32'h0, 32'd1, 32'd0);
    push(32'h408, 32'h0, 32'd1, 32'd0);
    rd(8'h14, v); chk("R8 queue full", v, 32'h8000_0000);
    rd(8'h0C, v); chk("R9 no overflow yet", v & 32'h0000_4000, 32'h0);
    push(32'h40C, 32'h0, 32'd1, 32'd0);
    rd(8'h0C, v); chk("R9 overflow flag", v & 32'h0000_4000, 32'h0000_4000);
    wait_idle("R8 drain");
    rd(8'h14, v); chk("R8 empty after drain", v, 32'h4000_0000);
    chk("R9 dropped push", 32'(scount - base), 32'd303);
    chk("R8 order B", slog[base+300], pat(256));
    chk("R8 order C", slog[base+301], pat(257));
    chk("R8 order D", slog[base+302], pat(258));

    finish_up();
  end
endmodule